// File: doc/BRIEF.md
# Register Rename Map and Free List

This block renames architectural register names into physical register tags at the decode stage, for a group of up to `W` instructions per cycle. It holds a map from every architectural register to the physical register that currently carries its value, and a circular free list of physical registers that hold no live value. A single pool of physical registers serves integer and floating-point destinations alike: a tag carries no register class.

For each valid lane of an accepted group the block returns the physical tags of both sources, a newly allocated destination tag, and the destination's previous mapping. The downstream reorder logic keeps that previous tag and hands it back on the release port when the instruction commits. Sources that read a destination written by an earlier lane of the same group are bypassed to that lane's new tag. A branch may ask for a snapshot of the map and of the free-list read pointer. A mispredict restores a snapshot in one cycle, which returns every register allocated since that point to the free list.

The group input is a valid/ready interface. `in_ready` is low during a restore cycle, and low whenever the free list holds fewer registers than the group has destinations. The upstream stage holds the same group stable until it sees `in_valid && in_ready` at a clock edge. The renamed tags are combinational and are valid in that accepting cycle, flagged by `out_valid`. There is no back-pressure on the output side. Releases and restores are plain control inputs and are always taken. `NUM_PHYS` must be a power of two.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register a maps to physical tag a for every a below `NUM_ARCH`. The free list holds tags `NUM_ARCH` to `NUM_PHYS-1`, which are handed out in ascending order.
- R2: Free tags are handed out strictly in the order in which they entered the free list. The free count never exceeds `NUM_PHYS-NUM_ARCH`.
- R3: A source in lane i takes the new tag of the highest lane j < i in the same group whose destination equals that source. If there is no such lane, the source takes the map entry.
- R4: Each valid lane with a destination receives a distinct tag from the head of the free list, in lane order. Its `out_prev` is the mapping of its destination as seen after all earlier lanes of the group, and it never equals its `out_dst`.
- R5: `in_ready` is low when the free count is below the number of lanes with both `in_lane_vld` and `in_has_dst` set. A stalled group changes neither the map nor the free list.
- R6: Set bits of `rel_vld` append their `rel_tag` values to the free list in lane order. Each appended tag adds one to the free count from the next cycle, and does not count toward the ready decision of the cycle in which it arrives.
- R7: A lane with `in_has_dst` low, or with `in_lane_vld` low, allocates no tag and leaves the map unchanged. The next destination lane receives the tag that lane would otherwise have taken.
- R8: An accepted group with `in_ckpt` high stores the map after the whole group, and the free-list head after its allocations, in slot `in_ckpt_slot`. A cycle with `restore` high drives `in_ready` low and reloads slot `restore_slot` for the next cycle.
- R9: Releases presented in a restore cycle are still appended to the free list, behind the tags that the restore rewinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group offered for renaming |
| in_ready | output | 1 | Group accepted at this edge when in_valid is high |
| in_lane_vld | input | W | Lane holds an instruction |
| in_has_dst | input | W | Lane writes a destination register |
| in_dst | input | W x AW | Destination architectural register per lane |
| in_src_a | input | W x AW | First source architectural register per lane |
| in_src_b | input | W x AW | Second source architectural register per lane |
| in_ckpt | input | 1 | Take a snapshot after this group |
| in_ckpt_slot | input | CW | Snapshot slot to write |
| out_valid | output | 1 | Renamed tags valid (group accepted) |
| out_src_a | output | W x PW | Physical tag of first source |
| out_src_b | output | W x PW | Physical tag of second source |
| out_dst | output | W x PW | Newly allocated destination tag |
| out_prev | output | W x PW | Previous mapping of the destination, freed at commit |
| rel_vld | input | W | Release lanes from commit |
| rel_tag | input | W x PW | Physical tags returned to the free list |
| restore | input | 1 | Mispredict: restore a snapshot |
| restore_slot | input | CW | Snapshot slot to restore |

## Verification
The first groups after reset read every architectural register with no destinations. This separates a correct identity map from one that is shifted or left uninitialised, and a group of four destinations then shows the ascending start of the free list. Hand-built groups put chained writes and reads of one register across lanes, and mix in lanes that have no destination or are invalid. These groups distinguish bypassing from the latest earlier lane from bypassing from the first one, and show whether an idle lane wrongly consumes a tag. The free list is drained to zero, with a group presented in the same cycle as a release, to tell a same-cycle count from a registered one. A snapshot, restore and release sequence, followed by a long random sweep with checkpoints that are either resolved or restored, compares every tag against an in-order model that renames each lane one after another.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // number of set bits in a lane vector (lanes are never wider than 32)
  function automatic int unsigned count_ones(input logic [31:0] v);
    count_ones = 0;
    for (int i = 0; i < 32; i++) count_ones += 32'(v[i]);
  endfunction
endpackage

// File: rtl/rr_freelist.sv
module rr_freelist #(
  parameter int NUM_PHYS = 32,
  parameter int NUM_ARCH = 12,
  parameter int W        = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  alloc_en,
  input  logic [$clog2(W+1)-1:0]                alloc_n,
  input  logic                                  rewind,
  input  logic [$clog2(NUM_PHYS):0]             rewind_ptr,
  input  logic [W-1:0]                          rel_vld,
  input  logic [W-1:0][$clog2(NUM_PHYS)-1:0]    rel_tag,
  output logic [W-1:0][$clog2(NUM_PHYS)-1:0]    cand,
  output logic [$clog2(NUM_PHYS):0]             head_ptr,
  output logic [$clog2(NUM_PHYS):0]             free_cnt
);
  localparam int PW        = $clog2(NUM_PHYS);
  localparam int PTRW      = PW + 1;
  localparam int INIT_FREE = NUM_PHYS - NUM_ARCH;

  logic [PW-1:0]         mem [NUM_PHYS];
  logic [PTRW-1:0]       head_q, tail_q;
  logic [W-1:0][PW-1:0]  wr_idx;
  logic [PTRW-1:0]       rel_n;

  // compacted write positions for the release lanes
  always_comb begin
    logic [PW-1:0] off;
    off = '0;
    for (int k = 0; k < W; k++) begin
      wr_idx[k] = tail_q[PW-1:0] + off;
      off       = off + PW'(rel_vld[k]);
    end
    rel_n = PTRW'(rr_pkg::count_ones(32'(rel_vld)));
  end

  // the next W tags from the head are offered to the lanes
  for (genvar k = 0; k < W; k++) begin : g_cand
    assign cand[k] = mem[head_q[PW-1:0] + PW'(k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++)
        mem[i] <= (i < INIT_FREE) ? PW'(NUM_ARCH + i) : '0;
      head_q <= '0;
      tail_q <= PTRW'(INIT_FREE);
    end else begin
      for (int k = 0; k < W; k++)
        if (rel_vld[k]) mem[wr_idx[k]] <= rel_tag[k];
      tail_q <= tail_q + rel_n;
      if (rewind)        head_q <= rewind_ptr;
      else if (alloc_en) head_q <= head_q + PTRW'(alloc_n);
    end
  end

  assign head_ptr = head_q;
  assign free_cnt = tail_q - head_q;
endmodule

// File: rtl/rr_maptable.sv
module rr_maptable #(
  parameter int NUM_ARCH = 12,
  parameter int NUM_PHYS = 32,
  parameter int W        = 4,
  parameter int NUM_CKPT = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       wr_en,
  input  logic [W-1:0]                               lane_wr,
  input  logic [W-1:0][$clog2(NUM_ARCH)-1:0]         wr_arch,
  input  logic [W-1:0][$clog2(NUM_PHYS)-1:0]         wr_tag,
  input  logic                                       ckpt_en,
  input  logic [$clog2(NUM_CKPT)-1:0]                ckpt_slot,
  input  logic                                       restore,
  input  logic [$clog2(NUM_CKPT)-1:0]                restore_slot,
  output logic [NUM_ARCH-1:0][$clog2(NUM_PHYS)-1:0]  map_q
);
  localparam int PW = $clog2(NUM_PHYS);

  typedef logic [NUM_ARCH-1:0][PW-1:0] map_t;

  map_t map_d;
  map_t snap_q [NUM_CKPT];

  // lanes written in order, so the latest lane to a register wins
  always_comb begin
    map_d = map_q;
    if (wr_en)
      for (int k = 0; k < W; k++)
        for (int a = 0; a < NUM_ARCH; a++)
          if (lane_wr[k] && 32'(wr_arch[k]) == a) map_d[a] = wr_tag[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PW'(a);
      for (int s = 0; s < NUM_CKPT; s++)
        for (int a = 0; a < NUM_ARCH; a++) snap_q[s][a] <= PW'(a);
    end else begin
      if (restore) map_q <= snap_q[restore_slot];
      else         map_q <= map_d;
      if (ckpt_en) snap_q[ckpt_slot] <= map_d;
    end
  end
endmodule

// File: rtl/rr_group.sv
module rr_group #(
  parameter int NUM_ARCH = 12,
  parameter int NUM_PHYS = 32,
  parameter int W        = 4
) (
  input  logic [W-1:0]                               lane_vld,
  input  logic [W-1:0]                               has_dst,
  input  logic [W-1:0][$clog2(NUM_ARCH)-1:0]         dst,
  input  logic [W-1:0][$clog2(NUM_ARCH)-1:0]         src_a,
  input  logic [W-1:0][$clog2(NUM_ARCH)-1:0]         src_b,
  input  logic [NUM_ARCH-1:0][$clog2(NUM_PHYS)-1:0]  map_q,
  input  logic [W-1:0][$clog2(NUM_PHYS)-1:0]         cand,
  output logic [W-1:0]                               lane_wr,
  output logic [W-1:0][$clog2(NUM_PHYS)-1:0]         pdst,
  output logic [W-1:0][$clog2(NUM_PHYS)-1:0]         psrc_a,
  output logic [W-1:0][$clog2(NUM_PHYS)-1:0]         psrc_b,
  output logic [W-1:0][$clog2(NUM_PHYS)-1:0]         pprev,
  output logic [$clog2(W+1)-1:0]                     ndst
);
  localparam int PW = $clog2(NUM_PHYS);
  localparam int AW = $clog2(NUM_ARCH);
  localparam int NW = $clog2(W + 1);

  function automatic logic [PW-1:0] map_rd(input logic [AW-1:0] a);
    map_rd = '0;
    for (int e = 0; e < NUM_ARCH; e++)
      if (32'(a) == e) map_rd = map_q[e];
  endfunction

  // destination tags: each destination lane takes the next candidate
  always_comb begin
    logic [NW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) begin
      lane_wr[i] = lane_vld[i] & has_dst[i];
      pdst[i]    = lane_wr[i] ? cand[n] : '0;
      n          = n + NW'(lane_wr[i]);
    end
    ndst = n;
  end

  // sources and previous mapping, bypassed from earlier lanes
  always_comb begin
    for (int i = 0; i < W; i++) begin
      psrc_a[i] = map_rd(src_a[i]);
      psrc_b[i] = map_rd(src_b[i]);
      pprev[i]  = map_rd(dst[i]);
      for (int j = 0; j < i; j++) begin
        if (lane_wr[j] && dst[j] == src_a[i]) psrc_a[i] = pdst[j];
        if (lane_wr[j] && dst[j] == src_b[i]) psrc_b[i] = pdst[j];
        if (lane_wr[j] && dst[j] == dst[i])   pprev[i]  = pdst[j];
      end
      if (!lane_wr[i]) pprev[i] = '0;
    end
  end
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_ARCH = 12,
  parameter int NUM_PHYS = 32,
  parameter int W        = 4,
  parameter int NUM_CKPT = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic [W-1:0]                            in_lane_vld,
  input  logic [W-1:0]                            in_has_dst,
  input  logic [W-1:0][$clog2(NUM_ARCH)-1:0]      in_dst,
  input  logic [W-1:0][$clog2(NUM_ARCH)-1:0]      in_src_a,
  input  logic [W-1:0][$clog2(NUM_ARCH)-1:0]      in_src_b,
  input  logic                                    in_ckpt,
  input  logic [$clog2(NUM_CKPT)-1:0]             in_ckpt_slot,
  output logic                                    out_valid,
  output logic [W-1:0][$clog2(NUM_PHYS)-1:0]      out_src_a,
  output logic [W-1:0][$clog2(NUM_PHYS)-1:0]      out_src_b,
  output logic [W-1:0][$clog2(NUM_PHYS)-1:0]      out_dst,
  output logic [W-1:0][$clog2(NUM_PHYS)-1:0]      out_prev,
  input  logic [W-1:0]                            rel_vld,
  input  logic [W-1:0][$clog2(NUM_PHYS)-1:0]      rel_tag,
  input  logic                                    restore,
  input  logic [$clog2(NUM_CKPT)-1:0]             restore_slot
);
  localparam int PW   = $clog2(NUM_PHYS);
  localparam int PTRW = PW + 1;
  localparam int NW   = $clog2(W + 1);

  logic [NUM_ARCH-1:0][PW-1:0] map_q;
  logic [W-1:0][PW-1:0]        cand;
  logic [W-1:0]                lane_wr;
  logic [NW-1:0]               ndst;
  logic [PTRW-1:0]             head_ptr, free_cnt;
  logic [PTRW-1:0]             snap_head_q [NUM_CKPT];
  logic                        accept;

  assign in_ready  = !restore && (free_cnt >= PTRW'(ndst));
  assign accept    = in_valid && in_ready;
  assign out_valid = accept;

  rr_group #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .W(W)) u_group (
    .lane_vld (in_lane_vld),
    .has_dst  (in_has_dst),
    .dst      (in_dst),
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .map_q    (map_q),
    .cand     (cand),
    .lane_wr  (lane_wr),
    .pdst     (out_dst),
    .psrc_a   (out_src_a),
    .psrc_b   (out_src_b),
    .pprev    (out_prev),
    .ndst     (ndst)
  );

  rr_maptable #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .W(W), .NUM_CKPT(NUM_CKPT)) u_map (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (accept),
    .lane_wr      (lane_wr),
    .wr_arch      (in_dst),
    .wr_tag       (out_dst),
    .ckpt_en      (accept && in_ckpt),
    .ckpt_slot    (in_ckpt_slot),
    .restore      (restore),
    .restore_slot (restore_slot),
    .map_q        (map_q)
  );

  rr_freelist #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .W(W)) u_free (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (accept),
    .alloc_n    (ndst),
    .rewind     (restore),
    .rewind_ptr (snap_head_q[restore_slot]),
    .rel_vld    (rel_vld),
    .rel_tag    (rel_tag),
    .cand       (cand),
    .head_ptr   (head_ptr),
    .free_cnt   (free_cnt)
  );

  // free-list head saved alongside each map snapshot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_CKPT; s++) snap_head_q[s] <= '0;
    end else if (accept && in_ckpt) begin
      snap_head_q[in_ckpt_slot] <= head_ptr + PTRW'(ndst);
    end
  end
endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int NUM_ARCH = 12,
  parameter int NUM_PHYS = 32,
  parameter int W        = 4
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 in_valid,
  input logic                                 in_ready,
  input logic                                 restore,
  input logic [W-1:0]                         in_lane_vld,
  input logic [W-1:0]                         in_has_dst,
  input logic [W-1:0][$clog2(NUM_PHYS)-1:0]   out_dst,
  input logic [W-1:0][$clog2(NUM_PHYS)-1:0]   out_prev,
  input logic [W-1:0]                         rel_vld,
  input logic [$clog2(NUM_PHYS):0]            free_cnt
);
  localparam int PTRW = $clog2(NUM_PHYS) + 1;

  a_r2_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= PTRW'(NUM_PHYS - NUM_ARCH));

  a_r5_short_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ($countones(in_lane_vld & in_has_dst) > int'(free_cnt))) |-> !in_ready);

  a_r8_restore_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    restore |-> !in_ready);

  a_r6_release_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !restore && $countones(rel_vld) == 1)
      |=> (free_cnt == $past(free_cnt) + PTRW'(1)));

  always @(posedge clk) begin
    if (rst_n && in_valid && in_ready) begin
      for (int i = 0; i < W; i++) begin
        if (in_lane_vld[i] && in_has_dst[i]) begin
          a_r4_fresh_tag: assert (out_dst[i] != out_prev[i]);
          for (int j = i + 1; j < W; j++)
            if (in_lane_vld[j] && in_has_dst[j])
              a_r4_unique_dst: assert (out_dst[i] != out_dst[j]);
        end
      end
    end
  end
endmodule

bind reg_rename rr_checker #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .restore     (restore),
  .in_lane_vld (in_lane_vld),
  .in_has_dst  (in_has_dst),
  .out_dst     (out_dst),
  .out_prev    (out_prev),
  .rel_vld     (rel_vld),
  .free_cnt    (free_cnt)
);

// File: tb/reg_rename_test.sv
module reg_rename_test;
  localparam int NA = 12, NP = 32, W = 4, NC = 4;
  localparam int AW = $clog2(NA), PW = $clog2(NP), CW = $clog2(NC);

  logic clk = 0, rst_n = 0;
  logic in_valid, in_ready, in_ckpt, out_valid, restore;
  logic [W-1:0] in_lane_vld, in_has_dst, rel_vld;
  logic [W-1:0][AW-1:0] in_dst, in_src_a, in_src_b;
  logic [CW-1:0] in_ckpt_slot, restore_slot;
  logic [W-1:0][PW-1:0] out_src_a, out_src_b, out_dst, out_prev, rel_tag;

  always #2 clk = ~clk;

  reg_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP), .W(W), .NUM_CKPT(NC)) uut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  // in-order reference: map, free FIFO, snapshots, pending old tags
  int mmap [NA];
  int fl [NP];
  int fh = 0, ft = NP - NA;
  int ck_map [NC][NA];
  int ck_h [NC];
  int pend [4096];
  int pf = 0, pc = 0, mark = 0;
  bit acc;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = 0; in_lane_vld = '0; in_has_dst = '0; in_dst = '0;
    in_src_a = '0; in_src_b = '0; in_ckpt = 0; in_ckpt_slot = '0;
    rel_vld = '0; rel_tag = '0; restore = 0; restore_slot = '0;
  endtask

  task automatic set_lane(input int i, input bit v, input bit d, input int dr, input int a, input int b);
    in_lane_vld[i] = v; in_has_dst[i] = d;
    in_dst[i] = AW'(dr); in_src_a[i] = AW'(a); in_src_b[i] = AW'(b);
  endtask

  task automatic add_rel(input int n, input int lim);
    for (int k = 0; k < n; k++)
      if (pf < lim) begin
        rel_vld[k] = 1; rel_tag[k] = PW'(pend[pf % 4096]); pf++;
      end
  endtask

  // evaluate one cycle against the in-order model, then advance
  task automatic cycle(input string tag);
    int nd;
    bit er;
    #1;
    nd = 0;
    for (int i = 0; i < W; i++) if (in_lane_vld[i] && in_has_dst[i]) nd++;
    er = !restore && ((ft - fh) >= nd);
    chk(tag, "in_ready", int'(in_ready), int'(er));
    acc = in_valid && er;
    if (in_valid) chk(tag, "out_valid", int'(out_valid), int'(er));
    if (acc) begin
      for (int i = 0; i < W; i++) begin
        if (in_lane_vld[i]) begin
          chk(tag, $sformatf("src_a lane%0d", i), int'(out_src_a[i]), mmap[in_src_a[i]]);
          chk(tag, $sformatf("src_b lane%0d", i), int'(out_src_b[i]), mmap[in_src_b[i]]);
          if (in_has_dst[i]) begin
            chk(tag, $sformatf("prev lane%0d", i), int'(out_prev[i]), mmap[in_dst[i]]);
            chk(tag, $sformatf("dst lane%0d", i), int'(out_dst[i]), fl[fh % NP]);
            pend[pc % 4096] = mmap[in_dst[i]]; pc++;
            mmap[in_dst[i]] = fl[fh % NP]; fh++;
          end
        end
      end
      if (in_ckpt) begin
        for (int a = 0; a < NA; a++) ck_map[in_ckpt_slot][a] = mmap[a];
        ck_h[in_ckpt_slot] = fh; mark = pc;
      end
    end
    for (int k = 0; k < W; k++)
      if (rel_vld[k]) begin fl[ft % NP] = int'(rel_tag[k]); ft++; end
    if (restore) begin
      for (int a = 0; a < NA; a++) mmap[a] = ck_map[restore_slot][a];
      fh = ck_h[restore_slot]; pc = mark;
    end
    @(negedge clk);
    clear_in();
  endtask

  task automatic group4(input string tag, input int base);
    in_valid = 1;
    for (int i = 0; i < W; i++) set_lane(i, 1, 1, (base + i) % NA, (base + 2 * i) % NA, (base + i + 5) % NA);
    cycle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int live, cslot, r, lim;
    for (int a = 0; a < NA; a++) mmap[a] = a;
    for (int i = 0; i < NP; i++) fl[i] = (i < NP - NA) ? NA + i : 0;
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: identity map read by all sources, then ascending first tags
    in_valid = 1;
    for (int i = 0; i < W; i++) set_lane(i, 1, 0, 0, i, i + 4);
    cycle("R1");
    in_valid = 1;
    for (int i = 0; i < W; i++) set_lane(i, 1, 1, i, 8 + i, 0);
    #1; chk("R1", "first new tag", int'(out_dst[0]), NA);
    chk("R1", "src reads reg 11", int'(out_src_a[3]), 11);
    cycle("R4");

    // R3: chained writes and reads of registers 5 and 6 in one group
    in_valid = 1;
    set_lane(0, 1, 1, 5, 5, 6);
    set_lane(1, 1, 1, 5, 5, 5);
    set_lane(2, 1, 1, 6, 5, 6);
    set_lane(3, 1, 0, 0, 6, 5);
    cycle("R3");

    // R7: no-destination and invalid lanes take no tag
    in_valid = 1;
    set_lane(0, 1, 0, 7, 7, 7);
    set_lane(1, 1, 1, 7, 7, 1);
    set_lane(2, 0, 1, 8, 2, 2);
    set_lane(3, 1, 1, 8, 7, 8);
    cycle("R7");

    // R5: drain the free list, then offer more destinations than are free
    while ((ft - fh) >= W) group4("R5", fh);
    in_valid = 1;
    for (int i = 0; i < W; i++) set_lane(i, 1, 1, i, i, i);
    cycle("R5");
    in_valid = 1;
    for (int i = 0; i < W; i++) set_lane(i, 1, i < (ft - fh), 9, i, 9);
    cycle("R5");

    // R6: releases are not visible to the ready decision of their own cycle
    add_rel(W, pc);
    group4("R6", 3);
    group4("R6", 6);

    // R8 / R9: snapshot, speculate, restore with a release in the same cycle
    add_rel(W, pc);
    cycle("R6");
    in_ckpt = 1; in_ckpt_slot = CW'(2);
    group4("R8", 1);
    add_rel(W, mark);
    cycle("R8");
    in_valid = 1;
    set_lane(0, 1, 1, 1, 1, 2);
    set_lane(1, 1, 1, 4, 1, 4);
    cycle("R8");
    restore = 1; restore_slot = CW'(2); in_valid = 1;
    for (int i = 0; i < W; i++) set_lane(i, 1, 1, i, i, i);
    add_rel(1, mark);
    cycle("R9");
    for (int g = 0; g < 3; g++) begin
      in_valid = 1;
      for (int i = 0; i < W; i++) set_lane(i, 1, 0, 0, g * W + i, (g * W + i + 6) % NA);
      cycle("R8");
    end
    group4("R9", 2);

    // R2: random sweep with checkpoints that are resolved or restored
    live = 0; cslot = 0;
    for (int it = 0; it < 4000; it++) begin
      in_valid = ($urandom % 8) != 0;
      for (int i = 0; i < W; i++)
        set_lane(i, ($urandom % 4) != 0, ($urandom % 3) != 0,
                 $urandom % NA, $urandom % NA, $urandom % NA);
      lim = live ? mark : pc;
      add_rel($urandom % 3, lim);
      r = $urandom % 16;
      if (!live && r < 2) begin
        in_ckpt = 1; cslot = $urandom % NC; in_ckpt_slot = CW'(cslot);
        cycle("R2");
        live = acc ? 1 : 0;
      end else if (live && r == 2) begin
        restore = 1; restore_slot = CW'(cslot);
        cycle("R8");
        live = 0;
      end else begin
        if (live && r == 3) live = 0;
        cycle("R2");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule